// File: doc/BRIEF.md
# Display Sync Timing Generator

This block drives the raster timing of a parallel RGB TFT panel: horizontal sync, vertical sync, data enable and a pixel-clock polarity select. Software writes the timing as four cumulative boundaries per axis. These are sync end, back-porch end, active end and total. Each boundary is written to a pending copy. The counters only use a shadow copy. A reload request moves the pending copy into the shadow copy, either on the next clock or on the first pixel of vertical blanking. The request bit stays set until that happens.

The block reports the live pixel position and a four-bit raster status. It raises a line event when the raster enters a programmed line, and a reload event when a commit happens. Both events latch into sticky flags, which software can mask and clear. All ports are plain control and status pins. The write port is a single-cycle strobe with no back-pressure: every cycle with `wr_en` high is taken.

Top module: `dsync_timing_gen`

## Requirements
- R1: After reset the position is 0, the block is disabled, all flags and reload bits are 0, `pclk_pol_o` is 0, and hsync, vsync and data enable sit at their inactive level, which is 1 because every polarity bit resets to 0 (active low).
- R2: While enabled, x counts up each clock until it reaches the shadow total width, then returns to 0 and y advances. After the shadow total height, y returns to 0. While disabled, both counters are held at 0.
- R3: Hsync is active while enabled and x ≤ sync boundary. Vsync is active while enabled and y ≤ vertical sync boundary. Status bit 3 reports hsync active and bit 2 reports vsync active.
- R4: Horizontal DE (status bit 1) is active for back-porch boundary < x ≤ active boundary. Vertical DE (status bit 0) uses the same rule on y. `de_o` is active when both are active.
- R5: Control register (address 4) bit 0 enables the block, taking effect one clock after the write. Bits 31, 30, 29 and 28 select the polarity of hsync, vsync, data enable and pixel clock. A polarity bit of 1 means active high, 0 means active low. `pclk_pol_o` carries bit 28.
- R6: Addresses 0 to 3 hold the sync, back-porch, active and total boundaries. Each holds the horizontal value in bits [27:16] and the vertical value in bits [10:0]. A write changes only the pending copy and has no effect on the outputs before a reload.
- R7: Writing address 5 with bit 0 set raises `reload_busy_o[0]` for one clock. On the following edge the shadow copy takes the pending values, both reload bits clear, and the reload flag is set.
- R8: Writing address 5 with bit 1 set raises `reload_busy_o[1]`. It stays set until the edge where x leaves the total width while y equals the active-height boundary. On that edge the shadow copy is updated, the bit clears, and flag bit 3 is set.
- R9: Flag bit 0 is set on the edge where the raster enters line L at x = 0. L is taken from bits [10:0] of address 6.
- R10: Flags, mask (address 7) and clear (address 8) share one layout: bit 0 is the line event and bit 3 is the reload event. Bits 1 and 2 always read 0. Writing 1 to a clear bit clears that flag, but a new event on the same edge wins over the clear. `irq_o` is the OR of the flags that are masked in.
- R11: `pos_o` carries x in bits [31:16] and y in bits [15:0], both zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync at the selected polarity |
| vsync_o | output | 1 | Vertical sync at the selected polarity |
| de_o | output | 1 | Data enable at the selected polarity |
| pclk_pol_o | output | 1 | Pixel-clock polarity select |
| pos_o | output | 32 | Current x in [31:16], y in [15:0] |
| status_o | output | 4 | {hsync, vsync, horizontal DE, vertical DE} active states |
| reload_busy_o | output | 2 | Pending vblank reload [1], immediate reload [0] |
| irq_flags_o | output | 4 | Sticky event flags |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default 12-bit horizontal and 11-bit vertical field widths. It programs tiny rasters of at most 17 by 12 pixels, so a frame lasts only a few hundred clocks. This puts dozens of line wraps, frame wraps, deferred commits and line events within reach of a short run. It also covers rasters with no front porch, where the deferred commit coincides with the frame wrap, and line targets at 0 and at the last line.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  localparam int unsigned NB     = 4;   // boundaries per axis
  localparam int unsigned H_LSB  = 16;  // horizontal field position
  localparam int unsigned HB_DEF = 12;
  localparam int unsigned VB_DEF = 11;

  // boundary index doubles as its register address
  typedef enum logic [1:0] {
    B_SYNC = 2'd0,
    B_BACK = 2'd1,
    B_ACTV = 2'd2,
    B_TOTL = 2'd3
  } bound_e;

  localparam int unsigned A_CTRL   = 4;
  localparam int unsigned A_RELOAD = 5;
  localparam int unsigned A_LINE   = 6;
  localparam int unsigned A_IMASK  = 7;
  localparam int unsigned A_ICLR   = 8;

  // polarity nibble comes from control bits [31:28]
  localparam int unsigned P_HS = 3;
  localparam int unsigned P_VS = 2;
  localparam int unsigned P_DE = 1;
  localparam int unsigned P_PC = 0;

  localparam int unsigned EV_LINE = 0;
  localparam int unsigned EV_RLD  = 3;
endpackage

// File: rtl/dsync_regs.sv
module dsync_regs
  import dsync_pkg::*;
#(
  parameter int unsigned H_BITS    = HB_DEF,
  parameter int unsigned V_BITS    = VB_DEF,
  parameter int unsigned ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 vblank_start,
  output logic [H_BITS-1:0]    sh_h [NB],
  output logic [V_BITS-1:0]    sh_v [NB],
  output logic                 ctrl_en,
  output logic [3:0]           pol,
  output logic [V_BITS-1:0]    line_pos,
  output logic [3:0]           imask,
  output logic [3:0]           clr,
  output logic [1:0]           busy,
  output logic                 commit
);
  logic imm_q, vbl_q;
  logic hit_ctrl, hit_rld, hit_line, hit_mask, hit_clr;
  logic unused_bits;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_BITS'(A_CTRL));
  assign hit_rld  = wr_en && (wr_addr == ADDR_BITS'(A_RELOAD));
  assign hit_line = wr_en && (wr_addr == ADDR_BITS'(A_LINE));
  assign hit_mask = wr_en && (wr_addr == ADDR_BITS'(A_IMASK));
  assign hit_clr  = wr_en && (wr_addr == ADDR_BITS'(A_ICLR));
  assign unused_bits = ^wr_data;

  assign commit = imm_q | (vbl_q & vblank_start);
  assign busy   = {vbl_q, imm_q};
  assign clr    = hit_clr ? wr_data[3:0] : 4'd0;

  // pending and shadow copy of each boundary pair
  for (genvar b = 0; b < NB; b++) begin : g_bound
    logic              hit;
    logic [H_BITS-1:0] pend_h, act_h;
    logic [V_BITS-1:0] pend_v, act_v;
    assign hit = wr_en && (wr_addr == ADDR_BITS'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_h <= '0;
        pend_v <= '0;
        act_h  <= '0;
        act_v  <= '0;
      end else begin
        if (hit) begin
          pend_h <= wr_data[H_LSB +: H_BITS];
          pend_v <= wr_data[V_BITS-1:0];
        end
        if (commit) begin
          act_h <= pend_h;
          act_v <= pend_v;
        end
      end
    end
    assign sh_h[b] = act_h;
    assign sh_v[b] = act_v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_q    <= 1'b0;
      vbl_q    <= 1'b0;
      ctrl_en  <= 1'b0;
      pol      <= 4'd0;
      line_pos <= '0;
      imask    <= 4'd0;
    end else begin
      if (commit) begin
        imm_q <= 1'b0;
        vbl_q <= 1'b0;
      end
      if (hit_rld) begin
        if (wr_data[0]) imm_q <= 1'b1;
        if (wr_data[1]) vbl_q <= 1'b1;
      end
      if (hit_ctrl) begin
        ctrl_en <= wr_data[0];
        pol     <= wr_data[31:28];
      end
      if (hit_line) line_pos <= wr_data[V_BITS-1:0];
      if (hit_mask) imask    <= wr_data[3:0];
    end
  end
endmodule

// File: rtl/dsync_counter.sv
module dsync_counter
  import dsync_pkg::*;
#(
  parameter int unsigned H_BITS = HB_DEF,
  parameter int unsigned V_BITS = VB_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [H_BITS-1:0] sh_h [NB],
  input  logic [V_BITS-1:0] sh_v [NB],
  input  logic [V_BITS-1:0] line_pos,
  output logic [H_BITS-1:0] x,
  output logic [V_BITS-1:0] y,
  output logic              hs_act,
  output logic              vs_act,
  output logic              hde,
  output logic              vde,
  output logic              vblank_start,
  output logic              line_hit
);
  logic              line_end;
  logic [V_BITS-1:0] y_nx;

  // >= keeps the raster bounded if a reload shrinks the total mid-line
  assign line_end = (x >= sh_h[B_TOTL]);
  assign y_nx     = (y >= sh_v[B_TOTL]) ? '0 : y + V_BITS'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      x <= '0;
      y <= '0;
    end else if (line_end) begin
      x <= '0;
      y <= y_nx;
    end else begin
      x <= x + H_BITS'(1);
    end
  end

  assign vblank_start = en && line_end && (y == sh_v[B_ACTV]);
  assign line_hit     = en && line_end && (y_nx == line_pos);

  assign hs_act = en && (x <= sh_h[B_SYNC]);
  assign vs_act = en && (y <= sh_v[B_SYNC]);
  assign hde    = en && (x > sh_h[B_BACK]) && (x <= sh_h[B_ACTV]);
  assign vde    = en && (y > sh_v[B_BACK]) && (y <= sh_v[B_ACTV]);
endmodule

// File: rtl/dsync_irq.sv
module dsync_irq #(
  parameter int unsigned N        = 4,
  parameter logic [N-1:0] SRC_MASK = 4'b1001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] imask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic unused_tied;
  assign unused_tied = ^((set | clr) & ~SRC_MASK);

  for (genvar i = 0; i < N; i++) begin : g_flag
    if (SRC_MASK[i]) begin : g_live
      logic f_q;
      always_ff @(posedge clk) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= (f_q & ~clr[i]) | set[i];
      end
      assign flags[i] = f_q;
    end else begin : g_tied
      assign flags[i] = 1'b0;
    end
  end

  assign irq = |(flags & imask);
endmodule

// File: rtl/dsync_timing_gen.sv
module dsync_timing_gen
  import dsync_pkg::*;
#(
  parameter int unsigned H_BITS    = HB_DEF,
  parameter int unsigned V_BITS    = VB_DEF,
  parameter int unsigned ADDR_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [31:0]          wr_data,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 de_o,
  output logic                 pclk_pol_o,
  output logic [31:0]          pos_o,
  output logic [3:0]           status_o,
  output logic [1:0]           reload_busy_o,
  output logic [3:0]           irq_flags_o,
  output logic                 irq_o
);
  logic [H_BITS-1:0] sh_h [NB];
  logic [V_BITS-1:0] sh_v [NB];
  logic              ctrl_en, commit, vblank_start, line_hit;
  logic [3:0]        pol, imask, clr, ev_set;
  logic [V_BITS-1:0] line_pos;
  logic [H_BITS-1:0] x;
  logic [V_BITS-1:0] y;
  logic              hs_act, vs_act, hde, vde;

  dsync_regs #(.H_BITS(H_BITS), .V_BITS(V_BITS), .ADDR_BITS(ADDR_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vblank_start(vblank_start), .sh_h(sh_h), .sh_v(sh_v), .ctrl_en(ctrl_en),
    .pol(pol), .line_pos(line_pos), .imask(imask), .clr(clr),
    .busy(reload_busy_o), .commit(commit)
  );

  dsync_counter #(.H_BITS(H_BITS), .V_BITS(V_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .sh_h(sh_h), .sh_v(sh_v),
    .line_pos(line_pos), .x(x), .y(y), .hs_act(hs_act), .vs_act(vs_act),
    .hde(hde), .vde(vde), .vblank_start(vblank_start), .line_hit(line_hit)
  );

  always_comb begin
    ev_set          = 4'd0;
    ev_set[EV_LINE] = line_hit;
    ev_set[EV_RLD]  = commit;
  end

  dsync_irq #(.N(4), .SRC_MASK(4'b1001)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(clr), .imask(imask),
    .flags(irq_flags_o), .irq(irq_o)
  );

  // polarity bit 1 = active high, so the pin equals XNOR of state and bit
  assign hsync_o    = ~(hs_act ^ pol[P_HS]);
  assign vsync_o    = ~(vs_act ^ pol[P_VS]);
  assign de_o       = ~((hde & vde) ^ pol[P_DE]);
  assign pclk_pol_o = pol[P_PC];
  assign pos_o      = {16'(x), 16'(y)};
  assign status_o   = {hs_act, vs_act, hde, vde};
endmodule

// File: rtl/dsync_timing_gen_chk.sv
module dsync_timing_gen_chk #(
  parameter int unsigned H_BITS    = 12,
  parameter int unsigned ADDR_BITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_BITS-1:0] wr_addr,
  input logic [31:0]          wr_data,
  input logic                 en,
  input logic [H_BITS-1:0]    tot_h,
  input logic                 pol_de,
  input logic [31:0]          pos_o,
  input logic [3:0]           status_o,
  input logic                 de_o,
  input logic [1:0]           reload_busy_o,
  input logic [3:0]           irq_flags_o
);
  logic imm_req;
  logic unused_wd;
  assign imm_req   = wr_en && (wr_addr == ADDR_BITS'(5)) && wr_data[0];
  assign unused_wd = ^wr_data[31:1];

  // R2: inside a line x steps by exactly one
  a_r2_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (16'(tot_h) > pos_o[31:16])) |=> (pos_o[31:16] == $past(pos_o[31:16]) + 16'd1));

  // R2: a disabled raster sits at the origin
  a_r2_home: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pos_o == 32'd0));

  // R7: an immediate request lasts one clock unless renewed
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_busy_o[0] && !imm_req) |=> !reload_busy_o[0]);

  // R8: clearing a deferred request always leaves the reload flag set
  a_r8_flag_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reload_busy_o[1]) |-> irq_flags_o[3]);

  // R5: data-enable pin follows both DE status bits at the chosen polarity
  a_r5_de_pin: assert property (@(posedge clk) disable iff (!rst_n)
    de_o == ~((status_o[0] & status_o[1]) ^ pol_de));

  // R10: unused flag positions never rise
  a_r10_tied_flags: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flags_o[2:1] == 2'b00);
endmodule

bind dsync_timing_gen dsync_timing_gen_chk #(.H_BITS(H_BITS), .ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en(ctrl_en), .tot_h(sh_h[3]), .pol_de(pol[1]), .pos_o(pos_o),
  .status_o(status_o), .de_o(de_o), .reload_busy_o(reload_busy_o),
  .irq_flags_o(irq_flags_o)
);

// File: tb/dsync_timing_gen_tb.sv
module dsync_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = 4'd0;
  logic [31:0] wr_data = 32'd0;
  logic        hsync_o, vsync_o, de_o, pclk_pol_o, irq_o;
  logic [31:0] pos_o;
  logic [3:0]  status_o, irq_flags_o;
  logic [1:0]  reload_busy_o;

  always #10 clk = ~clk;

  dsync_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_pol_o(pclk_pol_o),
    .pos_o(pos_o), .status_o(status_o), .reload_busy_o(reload_busy_o),
    .irq_flags_o(irq_flags_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit r6_mode = 0;

  // behavioural model state
  int mx, my, m_en, m_imm, m_vb, m_lpos;
  int sh_h[4], sh_v[4], pd_h[4], pd_v[4];
  logic [3:0] m_pol, m_ien, m_flg;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pair(input int h, input int v);
    return (32'(h) << 16) | 32'(v);
  endfunction

  task automatic model_update();
    bit lend, vbs, lin, cmt;
    int ny;
    lend = (mx >= sh_h[3]);
    ny   = (my >= sh_v[3]) ? 0 : my + 1;
    vbs  = (m_en != 0) && lend && (my == sh_v[2]);
    lin  = (m_en != 0) && lend && (ny == m_lpos);
    cmt  = (m_imm != 0) || ((m_vb != 0) && vbs);
    if (wr_en && wr_addr == 4'd8) m_flg = m_flg & ~wr_data[3:0];
    m_flg = m_flg & 4'b1001;
    if (lin) m_flg[0] = 1'b1;
    if (cmt) m_flg[3] = 1'b1;
    if (m_en == 0) begin mx = 0; my = 0; end
    else if (lend) begin mx = 0; my = ny; end
    else mx = mx + 1;
    if (cmt) begin
      for (int b = 0; b < 4; b++) begin sh_h[b] = pd_h[b]; sh_v[b] = pd_v[b]; end
      m_imm = 0; m_vb = 0;
    end
    if (wr_en) begin
      if (wr_addr < 4'd4) begin
        pd_h[wr_addr] = int'(wr_data[27:16]);
        pd_v[wr_addr] = int'(wr_data[10:0]);
      end
      case (wr_addr)
        4'd4: begin m_en = int'(wr_data[0]); m_pol = wr_data[31:28]; end
        4'd5: begin if (wr_data[0]) m_imm = 1; if (wr_data[1]) m_vb = 1; end
        4'd6: m_lpos = int'(wr_data[10:0]);
        4'd7: m_ien = wr_data[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic check_all();
    bit hs, vs, hd, vd;
    hs = (m_en != 0) && (mx <= sh_h[0]);
    vs = (m_en != 0) && (my <= sh_v[0]);
    hd = (m_en != 0) && (mx > sh_h[1]) && (mx <= sh_h[2]);
    vd = (m_en != 0) && (my > sh_v[1]) && (my <= sh_v[2]);
    check("R11", pos_o[31:16], 32'(mx));
    check("R2", pos_o[15:0], 32'(my));
    check("R3", status_o[3:2], {hs, vs});
    check("R4", status_o[1:0], {hd, vd});
    check("R5", {hsync_o, vsync_o, de_o, pclk_pol_o},
          {~(hs ^ m_pol[3]), ~(vs ^ m_pol[2]), ~((hd & vd) ^ m_pol[1]), m_pol[0]});
    check("R7", reload_busy_o[0], m_imm != 0);
    check("R8", {reload_busy_o[1], irq_flags_o[3]}, {m_vb != 0, m_flg[3]});
    check("R9", irq_flags_o[0], m_flg[0]);
    check("R10", {irq_flags_o, irq_o}, {m_flg, |(m_flg & m_ien)});
    if (r6_mode) check("R6", {status_o, pos_o[27:16], pos_o[11:0]},
                       {hs, vs, hd, vd, 12'(mx), 12'(my)});
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write_timing(input int hs, input int hb, input int ha, input int ht,
                              input int vs, input int vb, input int va, input int vt);
    wr(0, pair(hs, vs));
    wr(1, pair(hb, vb));
    wr(2, pair(ha, va));
    wr(3, pair(ht, vt));
  endtask

  task automatic random_timing(output int vt);
    int hs, hb, ha, ht, vs, vb, va;
    hs = $urandom % 3;  hb = hs + 1 + $urandom % 3;
    ha = hb + 1 + $urandom % 8; ht = ha + $urandom % 4;
    vs = $urandom % 2;  vb = vs + 1 + $urandom % 2;
    va = vb + 1 + $urandom % 6; vt = va + $urandom % 3;
    write_timing(hs, hb, ha, ht, vs, vb, va, vt);
  endtask

  task automatic wait_vb_commit();
    for (int i = 0; i < 600 && reload_busy_o[1]; i++) step();
    check("R8", reload_busy_o[1], 1'b0);
  endtask

  initial begin
    int vt;
    void'($urandom(32'd20240611));
    mx = 0; my = 0; m_en = 0; m_imm = 0; m_vb = 0; m_lpos = 0;
    m_pol = 4'd0; m_ien = 4'd0; m_flg = 4'd0;
    for (int b = 0; b < 4; b++) begin sh_h[b] = 0; sh_v[b] = 0; pd_h[b] = 0; pd_v[b] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen at the ports
    check("R1", pos_o, 32'd0);
    check("R1", {hsync_o, vsync_o, de_o, pclk_pol_o}, 4'b1110);
    check("R1", {status_o, reload_busy_o, irq_flags_o, irq_o}, 11'd0);

    // directed raster: 15 x 10, line target 5, immediate commit, then enable
    write_timing(1, 3, 11, 14, 0, 2, 7, 9);
    wr(6, 32'd5);
    wr(7, 32'h9);
    wr(5, 32'h1);
    step();
    wr(4, 32'hA000_0001);
    run(400);
    wr(8, 32'h9);                         // R10 clear both
    run(20);

    // R6: pending writes leave the running raster untouched
    r6_mode = 1;
    write_timing(0, 2, 9, 12, 1, 2, 6, 8);
    run(60);
    r6_mode = 0;
    wr(5, 32'h2);                          // R8 deferred commit
    wait_vb_commit();
    run(50);

    // R9 corner: line 0 is hit only at frame wrap
    wr(6, 32'd0);
    run(250);

    // random rasters, deferred and immediate commits, random polarity
    for (int k = 0; k < 14; k++) begin
      r6_mode = 1;
      random_timing(vt);
      run($urandom % 40);
      r6_mode = 0;
      wr(6, 32'($urandom % (vt + 1)));
      wr(4, {4'($urandom), 27'd0, 1'b1});
      if ($urandom % 4 == 0) begin
        wr(5, 32'h1);
        run(1);
      end else begin
        wr(5, 32'h2);
        wait_vb_commit();
      end
      run(80 + $urandom % 200);
      if ($urandom % 2) wr(8, 32'($urandom % 16));
    end

    // corner: no front porch, commit lands on the frame wrap
    write_timing(0, 1, 5, 5, 0, 1, 4, 4);
    wr(5, 32'h2);
    wait_vb_commit();
    run(60);

    // R2: disable returns to origin, enable restarts
    wr(4, 32'h0);
    run(10);
    wr(4, 32'h5000_0001);
    run(100);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule